// File: doc/BRIEF.md
# Event and Interval Down-Counter

This block is a 16-bit down-counter that a processor programs through a small byte-wide register window. It runs in one of two modes. As an interval timer it counts system clocks. As an event counter it counts falling edges seen on an asynchronous input, which is first brought into the clock domain by a short synchronizer. When the count steps from one to zero, an interrupt flag is raised and driven on the `irq` output.

Only the low byte of the start value is held in a staging register. Software writes that byte first. The write of the high byte then loads the whole counter at once, starts it, clears any pending flag and arms the flag for one event. After the event the counter keeps counting down and wraps, but the flag stays quiet until software loads the counter again. Software acknowledges an event by reading the low count byte.

Top module: `evt_timer`

## Requirements
- R1: Reset (synchronous, active high) clears the counter, the low-byte staging register, the mode bit and the interrupt flag. `irq` is low and every register reads 0x00.
- R2: A write to address 0 stores `wdata` in the low-byte staging register only. The counter keeps running from its current value.
- R3: A write to address 1 loads the counter with {`wdata`, staging byte}, clears the flag and arms it. The counter does not step in the cycle of the load.
- R4: With the mode bit at 0, the counter decrements by one on every clock after the load cycle. A load of N therefore reaches zero N clocks after the load edge.
- R5: With the mode bit at 1, the counter decrements once for each falling edge of `pulse_in`, taken after a two-stage synchronizer. The count changes on the third rising clock edge after the input falls. Rising edges and steady levels leave the count unchanged.
- R6: The flag is set on the step that takes the counter from 1 to 0 while the flag is armed, and `irq` follows the flag.
- R7: Once set, the flag is disarmed. While the counter wraps and passes through zero again, no new flag is raised until the next write to address 1.
- R8: A read of address 0 (`rd_en` high) clears the flag. If a setting step falls in the same cycle, the set takes priority.
- R9: Read data is combinational from `addr`: 0 gives the count low byte, 1 the count high byte, 2 the mode in bit 0 with the upper bits zero, and 3 the flag in bit 0 with the upper bits zero.
- R10: A write to address 2 stores bit 0 of `wdata` as the mode and ignores the other bits. A write to address 3 changes nothing.
- R11: Reads of addresses 1, 2 and 3 leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| pulse_in | input | 1 | Asynchronous event input, counted on falling edges |
| irq | output | 1 | Interrupt flag |

## Verification
The assertions assume that `wr_en` and `rd_en` are single-cycle strobes aligned to `clk`. They also assume that any high or low level on `pulse_in` lasts at least two clock periods, so the synchronizer never merges or loses an edge. The stimulus changes every input only on the falling clock edge. It keeps each `pulse_in` level for four clocks and never asserts both strobes together. Because reads are combinational, the bench samples `rdata` half a cycle before the edge that would apply a read's side effect.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 2;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_CNT_LO = 2'd0,
        REG_CNT_HI = 2'd1,
        REG_MODE   = 2'd2,
        REG_STAT   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        MODE_CLOCK = 1'b0,
        MODE_PULSE = 1'b1
    } cnt_mode_e;

    // Request from the register window to the counter core
    typedef struct packed {
        logic load;
        cnt_t value;
        logic clr_flag;
    } load_req_t;

    function automatic cnt_t join_bytes(input byte_t hi, input byte_t lo);
        return {hi, lo};
    endfunction

    function automatic byte_t pick_byte(input cnt_t v, input logic upper);
        return upper ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
    endfunction

    function automatic byte_t bit_to_byte(input logic b);
        return {{(BYTE_W-1){1'b0}}, b};
    endfunction

endpackage

// File: rtl/evt_timer_sync.sv
module evt_timer_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic fall
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain;

    // Stage 0 samples the raw input; the last stage is the edge-history bit
    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= async_in;
    end

    generate
        for (genvar i = 1; i < CHAIN; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign fall = chain[CHAIN-1] & ~chain[CHAIN-2];

    // R5: one input edge yields a single step pulse
    p_fall_single_r5: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/evt_timer_regif.sv
module evt_timer_regif
    import evt_timer_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  byte_t               wdata,
    input  cnt_t                count,
    input  logic                flag,
    output load_req_t           req,
    output cnt_mode_e           mode,
    output byte_t               rdata
);
    reg_sel_e sel;
    byte_t    stage_lo;

    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_lo <= '0;
            mode     <= MODE_CLOCK;
        end else if (wr_en) begin
            case (sel)
                REG_CNT_LO: stage_lo <= wdata;
                REG_MODE:   mode     <= cnt_mode_e'(wdata[0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        req.load     = wr_en && (sel == REG_CNT_HI);
        req.value    = join_bytes(wdata, stage_lo);
        req.clr_flag = rd_en && (sel == REG_CNT_LO);
    end

    always_comb begin
        case (sel)
            REG_CNT_LO: rdata = pick_byte(count, 1'b0);
            REG_CNT_HI: rdata = pick_byte(count, 1'b1);
            REG_MODE:   rdata = bit_to_byte(mode == MODE_PULSE);
            default:    rdata = bit_to_byte(flag);
        endcase
    end

    // R10: mode changes only through a write of its own address
    p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel == REG_MODE) |=> $stable(mode));

    // R2: staging byte only changes on a low-byte write
    p_stage_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel == REG_CNT_LO) |=> $stable(stage_lo));

endmodule

// File: rtl/evt_timer_count.sv
module evt_timer_count
    import evt_timer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  load_req_t req,
    input  logic      step,
    output cnt_t      count,
    output logic      flag
);
    localparam cnt_t ONE = cnt_t'(1);

    logic armed;
    logic hit;

    assign hit = step && !req.load && armed && (count == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            armed <= 1'b0;
            flag  <= 1'b0;
        end else if (req.load) begin
            count <= req.value;
            armed <= 1'b1;
            flag  <= 1'b0;
        end else begin
            if (step)          count <= count - ONE;
            if (hit) begin
                armed <= 1'b0;
                flag  <= 1'b1;
            end else if (req.clr_flag) begin
                flag  <= 1'b0;
            end
        end
    end

    // R3: a load places the requested value in the counter
    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        req.load |=> (count == $past(req.value)) && !flag);

    // R4: a step without a load moves the count down by one
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (step && !req.load) |=> count == $past(count) - ONE);

    // R5: no step and no load keeps the count
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!step && !req.load) |=> $stable(count));

    // R6: the flag rises only together with a zero count
    p_flag_zero_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> count == '0);

    // R7: a disarmed counter cannot raise the flag without a reload
    p_no_rearm_r7: assert property (@(posedge clk) disable iff (rst)
        (!armed && !req.load) |=> !$rose(flag));

    // R8: an acknowledge with no competing event drops the flag
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (req.clr_flag && count != ONE) |=> !flag);

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              pulse_in,
    output logic              irq
);
    load_req_t req;
    cnt_mode_e mode;
    cnt_t      count;
    logic      flag;
    logic      fall;
    logic      step;

    evt_timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pulse_in),
        .fall     (fall)
    );

    evt_timer_regif u_regif (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .count (count),
        .flag  (flag),
        .req   (req),
        .mode  (mode),
        .rdata (rdata)
    );

    assign step = (mode == MODE_PULSE) ? fall : 1'b1;

    evt_timer_count u_count (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .step  (step),
        .count (count),
        .flag  (flag)
    );

    assign irq = flag;

    // R5: in event mode the count never moves without a synchronized fall
    p_pulse_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PULSE && !fall && !req.load) |=> $stable(count));

endmodule

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       pulse_in = 1'b1;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    evt_timer u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pulse_in(pulse_in), .irq(irq)
    );

    localparam logic [1:0] K_WR = 2'd0;
    localparam logic [1:0] K_RD = 2'd1;
    localparam logic [1:0] K_ID = 2'd2;

    typedef struct packed {
        logic [1:0] kind;
        logic [1:0] a;
        logic [7:0] d;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 27;
    // Each entry occupies one clock in clock mode; expected values follow the running count
    localparam vec_t VECS [NV] = '{
        '{K_WR, 2'd2, 8'h00, 8'h00},  // mode = clock
        '{K_WR, 2'd0, 8'h05, 8'h00},  // staging = 05
        '{K_RD, 2'd3, 8'h00, 8'h00},  // flag clear
        '{K_WR, 2'd1, 8'h00, 8'h00},  // load 0x0005 (R3)
        '{K_RD, 2'd0, 8'h00, 8'h05},  // R4
        '{K_RD, 2'd1, 8'h00, 8'h00},
        '{K_RD, 2'd3, 8'h00, 8'h00},
        '{K_ID, 2'd0, 8'h00, 8'h00},
        '{K_RD, 2'd0, 8'h00, 8'h01},  // read-clear collides with hit: set wins (R8)
        '{K_RD, 2'd3, 8'h00, 8'h01},  // R6
        '{K_RD, 2'd1, 8'h00, 8'hFF},  // wrapped, R11
        '{K_RD, 2'd3, 8'h00, 8'h01},  // R11
        '{K_RD, 2'd0, 8'h00, 8'hFD},  // clears flag
        '{K_RD, 2'd3, 8'h00, 8'h00},  // R8
        '{K_WR, 2'd0, 8'h33, 8'h00},  // R2 staging only
        '{K_RD, 2'd1, 8'h00, 8'hFF},
        '{K_RD, 2'd0, 8'h00, 8'hF9},
        '{K_WR, 2'd3, 8'hFF, 8'h00},  // R10 ignored
        '{K_RD, 2'd3, 8'h00, 8'h00},
        '{K_RD, 2'd2, 8'h00, 8'h00},
        '{K_WR, 2'd1, 8'h12, 8'h00},  // load 0x1233
        '{K_RD, 2'd1, 8'h00, 8'h12},
        '{K_RD, 2'd0, 8'h00, 8'h32},
        '{K_WR, 2'd2, 8'hFF, 8'h00},  // mode = pulse, bit0 only
        '{K_RD, 2'd2, 8'h00, 8'h01},  // R9
        '{K_RD, 2'd0, 8'h00, 8'h30},  // R5 hold
        '{K_RD, 2'd0, 8'h00, 8'h30}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [1:0] a, input string tag, input logic [7:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_ack();
        @(negedge clk);
        rd_en = 1'b1; addr = 2'd0;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_fall();
        @(negedge clk);
        pulse_in = 1'b0;
        repeat (4) @(negedge clk);
        pulse_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic reset_check(input string tag);
        peek(2'd0, tag, 8'h00);
        peek(2'd1, tag, 8'h00);
        peek(2'd2, tag, 8'h00);
        peek(2'd3, tag, 8'h00);
        chk(tag, {7'd0, irq}, 8'h00);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        reset_check("R1 after power-up reset");

        // Table walk, one clock per entry
        for (int i = 0; i < NV; i++) begin
            wr_en = (VECS[i].kind == K_WR);
            rd_en = (VECS[i].kind == K_RD);
            addr  = VECS[i].a;
            wdata = VECS[i].d;
            #1;
            if (VECS[i].kind == K_RD) begin
                n_chk++;
                if (rdata !== VECS[i].exp) begin
                    n_fail++;
                    $display("FAIL table vector %0d (R2 R4 R6 R8 R9 R10 R11) actual %h expected %h",
                             i, rdata, VECS[i].exp);
                end
            end
            @(negedge clk);
        end
        wr_en = 1'b0; rd_en = 1'b0;

        // R5/R6: event counting in pulse mode
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h00);
        peek(2'd0, "R3 pulse-mode load", 8'h03);
        pulse_fall();
        peek(2'd0, "R5 one falling edge", 8'h02);
        repeat (6) @(negedge clk);
        peek(2'd0, "R5 steady high level", 8'h02);
        pulse_fall();
        pulse_fall();
        peek(2'd0, "R5 third falling edge", 8'h00);
        chk("R6 irq in pulse mode", {7'd0, irq}, 8'h01);

        // R5: exact latency, count changes after the third edge
        wr(2'd0, 8'h09);
        wr(2'd1, 8'h00);
        @(negedge clk); pulse_in = 1'b0;
        @(negedge clk); @(negedge clk);
        peek(2'd0, "R5 before third edge", 8'h09);
        @(negedge clk);
        peek(2'd0, "R5 at third edge", 8'h08);
        repeat (4) @(negedge clk); pulse_in = 1'b1;
        repeat (4) @(negedge clk);

        // R4/R6/R7: clock mode, arrival time and one-shot behaviour
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h00);
        chk("R4 irq low one edge after load", {7'd0, irq}, 8'h00);
        @(negedge clk);
        chk("R4 irq low two edges after load", {7'd0, irq}, 8'h00);
        @(negedge clk);
        chk("R6 irq at zero", {7'd0, irq}, 8'h01);
        rd_ack();
        chk("R8 acknowledge", {7'd0, irq}, 8'h00);
        repeat (65540) @(negedge clk);
        chk("R7 no flag after wrap", {7'd0, irq}, 8'h00);
        wr(2'd1, 8'h00);
        repeat (2) @(negedge clk);
        chk("R3 reload rearms", {7'd0, irq}, 8'h01);
        wr(2'd1, 8'h40);
        chk("R3 load clears flag", {7'd0, irq}, 8'h00);

        // R1: reset while running
        wr(2'd2, 8'h01);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        reset_check("R1 mid-run reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule